// File: doc/BRIEF.md
# Set-Associative Translation Buffer for Directory and Leaf Entries

This block holds recently used translations for a two-level page-table scheme. A lookup presents a 20-bit virtual page number and a 12-bit page offset. One clock later the block answers with a leaf result and a directory result. The leaf result is either a hit carrying the physical address or a miss that asks for a table walk. The directory result says whether the first-level entry covering the page is already held, so a walker can skip that memory read.

The array holds 16 sets of 4 ways. Every way is marked with a kind flag: directory entry or leaf table entry. The external walker writes entries back through a fill port. A context-switch flush strobe removes every entry except those whose global bit is set. Walking the tables and checking permissions are done outside this block.

Top module: `tlbx_top`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) empties the array. Every response output reads 0 after reset, and any later lookup misses until a fill is made.
- R2: A lookup whose leaf entry is held sets rsp_hit one cycle after lk_req. In that cycle rsp_miss is low and rsp_pa = {entry[31:12], lk_off}.
- R3: A lookup with no matching leaf entry sets rsp_miss one cycle after lk_req. In that cycle rsp_hit is low and rsp_pa is 0.
- R4: Leaf entries are placed by set index vpn[3:0] and compared on tag vpn[19:4]. A page that shares the tag but has another index misses. So does a page that shares the index but has another tag.
- R5: A directory fill (fill_pd=1) is keyed by vpn[19:10]. It uses set vpn[13:10] and tag {10'b0, vpn[19:14]}. Any lookup with the same vpn[19:10] raises rsp_dir_hit and returns the entry on rsp_dir_ent; otherwise both read 0. A directory entry never produces a leaf hit, and a leaf entry whose key equals a directory key stays separate from it.
- R6: A flush clears every entry whose bit 8 (global) is 0 and keeps every entry whose bit 8 is 1.
- R7: A fill into a set that has an invalid way takes the lowest-numbered invalid way. Four distinct tags in one set therefore all stay resident.
- R8: When the set is full, the victim comes from a 3-bit tree pseudo-LRU per set. Leaf hits and fills update the tree. The most recently touched way is never the next victim.
- R9: A fill whose tag and kind match a valid way overwrites that way. It never creates a second copy, and no other way in the set is evicted.
- R10: Responses appear exactly one cycle after lk_req. In a cycle after lk_req was low, rsp_hit, rsp_miss and rsp_dir_hit are all low.
- R11: When a fill and a flush arrive in the same cycle, the flush is applied first. The filled entry survives even if its global bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup strobe |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_off | input | 12 | Page offset carried into the physical address |
| fill_req | input | 1 | Fill strobe |
| fill_pd | input | 1 | Fill kind: 1 directory entry, 0 leaf entry |
| fill_vpn | input | 20 | Virtual page number the fill belongs to |
| fill_ent | input | 32 | Entry contents; bits 31:12 frame, bit 8 global |
| flush_req | input | 1 | Context-switch flush strobe |
| rsp_hit | output | 1 | Leaf hit for the previous cycle's lookup |
| rsp_miss | output | 1 | Leaf miss, walk request |
| rsp_pa | output | 32 | Physical address on a leaf hit, else 0 |
| rsp_dir_hit | output | 1 | Directory entry for the looked-up page is held |
| rsp_dir_ent | output | 32 | Held directory entry, else 0 |

## Verification
Four leaf fills into one set with distinct tags check whether the invalid way is preferred, since every one of them must then hit. A fifth tag, entered after a chosen order of hits, tells tree pseudo-LRU apart from plain round-robin or first-way replacement: only one particular way may be lost. Refilling a resident tag separates overwriting from double allocation, because the other residents must keep hitting. Directory and leaf fills with colliding keys, followed by a flush over a mix of global and local entries, check kind separation and the global rule.

// File: rtl/tlbx_pkg.sv
// Package: shared sizes, the way record and key derivation for the translation buffer.
// Assumes a 4-way set (the replacement tree is fixed at 3 bits).
package tlbx_pkg;
    localparam int VPN_W  = 20;               // virtual page number width
    localparam int OFF_W  = 12;               // page offset width
    localparam int SET_W  = 4;                // set index width
    localparam int SETS   = 1 << SET_W;       // number of sets
    localparam int WAYS   = 4;                // ways per set
    localparam int WAY_W  = $clog2(WAYS);     // way index width
    localparam int TAG_W  = VPN_W - SET_W;    // stored tag width
    localparam int ENT_W  = 32;               // entry contents width
    localparam int PPN_W  = ENT_W - OFF_W;    // frame number width
    localparam int DIR_SH = 10;               // low VPN bits covered by one directory entry
    localparam int G_BIT  = 8;                // global flag position in an entry

    typedef struct packed {
        logic             vld;
        logic             pd;                 // 1 directory entry, 0 leaf entry
        logic [TAG_W-1:0] tag;
        logic [ENT_W-1:0] ent;
    } way_t;

    // Derive the lookup key: directory entries are keyed by the upper VPN field.
    function automatic logic [VPN_W-1:0] key_of(input logic [VPN_W-1:0] vpn, input logic pd);
        key_of = pd ? (vpn >> DIR_SH) : vpn;
    endfunction
endpackage

// File: rtl/tlbx_probe.sv
// Module: compares one set's ways against a tag and kind, returns the match.
// Assumes at most one way matches; the lowest-numbered match is reported.
module tlbx_probe
    import tlbx_pkg::*;
(
    input  way_t [WAYS-1:0]  set_i,
    input  logic             pd_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic [WAYS-1:0]  match_o,
    output logic             hit_o,
    output logic [WAY_W-1:0] way_o,
    output logic [ENT_W-1:0] ent_o
);
    // Per-way compare of valid, kind and tag.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            match_o[w] = set_i[w].vld && (set_i[w].pd == pd_i) && (set_i[w].tag == tag_i);
        end
    end

    // Encode the matching way and select its contents.
    always_comb begin
        way_o = '0;
        ent_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_o[w]) begin
                way_o = WAY_W'(w);
                ent_o = set_i[w].ent;
            end
        end
        hit_o = |match_o;
    end
endmodule

// File: rtl/tlbx_plru.sv
// Module: 3-bit tree pseudo-LRU for one 4-way set.
// Bit 0 picks the half holding the victim (0 ways 0-1, 1 ways 2-3);
// bits 1 and 2 pick within the left and right half. A touch points the tree away.
module tlbx_plru
    import tlbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_i,
    input  logic [WAY_W-1:0] touch_way_i,
    output logic [WAY_W-1:0] victim_o
);
    logic [2:0] tree;

    // Update the tree so that the touched way is not the next victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tree <= '0;
        end else if (touch_i) begin
            if (!touch_way_i[1]) begin
                tree[0] <= 1'b1;
                tree[1] <= ~touch_way_i[0];
            end else begin
                tree[0] <= 1'b0;
                tree[2] <= ~touch_way_i[0];
            end
        end
    end

    // Decode the victim from the tree.
    always_comb begin
        if (tree[0]) victim_o = tree[2] ? 2'd3 : 2'd2;
        else         victim_o = tree[1] ? 2'd1 : 2'd0;
    end

    // R8: the way just touched is not the following victim.
    a_r8_victim_moves_off: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> victim_o != $past(touch_way_i));
endmodule

// File: rtl/tlbx_top.sv
// Module: 16-set, 4-way translation buffer holding directory and leaf entries.
// Lookups answer one cycle later; fills write in one cycle; a flush keeps global
// entries. Assumes the walker fills with correctly formed entries.
module tlbx_top
    import tlbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [OFF_W-1:0] lk_off,
    input  logic             fill_req,
    input  logic             fill_pd,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [ENT_W-1:0] fill_ent,
    input  logic             flush_req,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [ENT_W-1:0] rsp_pa,
    output logic             rsp_dir_hit,
    output logic [ENT_W-1:0] rsp_dir_ent
);
    way_t [WAYS-1:0] mem [SETS];

    logic [VPN_W-1:0] dkey, fkey;
    logic [SET_W-1:0] lset, dset, fset;
    logic [WAYS-1:0]  l_match, d_match, f_match;
    logic             l_hit, d_hit, f_hit;
    logic [WAY_W-1:0] l_way, d_way, f_way, fway;
    logic [ENT_W-1:0] l_ent, d_ent, f_ent;
    logic [WAY_W-1:0] vict [SETS];
    logic             inv_any;
    logic [WAY_W-1:0] inv_way;

    // Key and set derivation for the lookup and the fill.
    always_comb begin
        dkey = key_of(lk_vpn, 1'b1);
        fkey = key_of(fill_vpn, fill_pd);
        lset = lk_vpn[SET_W-1:0];
        dset = dkey[SET_W-1:0];
        fset = fkey[SET_W-1:0];
    end

    tlbx_probe u_leaf (.set_i(mem[lset]), .pd_i(1'b0), .tag_i(lk_vpn[VPN_W-1:SET_W]),
                       .match_o(l_match), .hit_o(l_hit), .way_o(l_way), .ent_o(l_ent));
    tlbx_probe u_dir  (.set_i(mem[dset]), .pd_i(1'b1), .tag_i(dkey[VPN_W-1:SET_W]),
                       .match_o(d_match), .hit_o(d_hit), .way_o(d_way), .ent_o(d_ent));
    tlbx_probe u_fill (.set_i(mem[fset]), .pd_i(fill_pd), .tag_i(fkey[VPN_W-1:SET_W]),
                       .match_o(f_match), .hit_o(f_hit), .way_o(f_way), .ent_o(f_ent));

    // Lowest-numbered invalid way in the fill set.
    always_comb begin
        inv_any = 1'b0;
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!mem[fset][w].vld) begin
                inv_any = 1'b1;
                inv_way = WAY_W'(w);
            end
        end
    end

    // Fill way: matching copy first, then an invalid way, then the tree victim.
    always_comb begin
        if (f_hit)        fway = f_way;
        else if (inv_any) fway = inv_way;
        else              fway = vict[fset];
    end

    // One replacement tree per set; fills win over leaf hits in the same set.
    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic             fill_here, look_here, touch;
        logic [WAY_W-1:0] twy;
        always_comb begin
            fill_here = fill_req && (fset == SET_W'(s));
            look_here = lk_req && l_hit && (lset == SET_W'(s));
            touch     = fill_here || look_here;
            twy       = fill_here ? fway : l_way;
        end
        tlbx_plru u_plru (.clk(clk), .rst_n(rst_n), .touch_i(touch),
                          .touch_way_i(twy), .victim_o(vict[s]));
    end

    // Array update: reset clears, flush drops local entries, then the fill writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    mem[s][w].vld <= 1'b0;
        end else begin
            if (flush_req) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        if (!mem[s][w].ent[G_BIT]) mem[s][w].vld <= 1'b0;
            end
            if (fill_req) mem[fset][fway] <= '{vld: 1'b1, pd: fill_pd,
                                                tag: fkey[VPN_W-1:SET_W], ent: fill_ent};
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit     <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_pa      <= '0;
            rsp_dir_hit <= 1'b0;
            rsp_dir_ent <= '0;
        end else begin
            rsp_hit     <= lk_req && l_hit;
            rsp_miss    <= lk_req && !l_hit;
            rsp_pa      <= (lk_req && l_hit) ? {l_ent[ENT_W-1:OFF_W], lk_off} : '0;
            rsp_dir_hit <= lk_req && d_hit;
            rsp_dir_ent <= (lk_req && d_hit) ? d_ent : '0;
        end
    end

    // Summaries of array state used only by the checks below.
    logic any_vld, ng_live;
    always_comb begin
        any_vld = 1'b0;
        ng_live = 1'b0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                any_vld = any_vld | mem[s][w].vld;
                ng_live = ng_live | (mem[s][w].vld & ~mem[s][w].ent[G_BIT]);
            end
    end

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !any_vld);
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_pa[OFF_W-1:0] == $past(lk_off));
    a_r6_flush_drops_local: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !fill_req) |=> !ng_live);
    a_r9_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> ($onehot0(l_match) && $onehot0(d_match)));
    a_r10_quiet_without_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!rsp_hit && !rsp_miss && !rsp_dir_hit));
endmodule

// File: tb/tb_tlbx_top.sv
`timescale 1ns/1ps
module tb_tlbx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, fill_req = 1'b0, fill_pd = 1'b0, flush_req = 1'b0;
    logic [19:0] lk_vpn = '0, fill_vpn = '0;
    logic [11:0] lk_off = '0;
    logic [31:0] fill_ent = '0;
    logic        rsp_hit, rsp_miss, rsp_dir_hit;
    logic [31:0] rsp_pa, rsp_dir_ent;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    tlbx_top dut (.clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_off(lk_off),
                  .fill_req(fill_req), .fill_pd(fill_pd), .fill_vpn(fill_vpn), .fill_ent(fill_ent),
                  .flush_req(flush_req), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa),
                  .rsp_dir_hit(rsp_dir_hit), .rsp_dir_ent(rsp_dir_ent));

    // op: 0 lookup (dat[11:0] = offset), 1 leaf fill, 2 directory fill, 3 flush
    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] vpn;
        logic [31:0] dat;
        logic        eh;
        logic [31:0] epa;
        logic        ed;
        logic [31:0] edent;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 20'h10005, 32'h123,      1'b0, 32'h0,        1'b0, 32'h0,        4'd3},  // R3 empty
        '{2'd1, 20'h10005, 32'hAAAAA001, 1'b0, 32'h0,        1'b0, 32'h0,        4'd7},  // R7 way0
        '{2'd0, 20'h10005, 32'h123,      1'b1, 32'hAAAAA123, 1'b0, 32'h0,        4'd2},  // R2
        '{2'd1, 20'h20005, 32'hBBBBB001, 1'b0, 32'h0,        1'b0, 32'h0,        4'd7},
        '{2'd1, 20'h30005, 32'hCCCCC001, 1'b0, 32'h0,        1'b0, 32'h0,        4'd7},
        '{2'd1, 20'h40005, 32'hDDDDD101, 1'b0, 32'h0,        1'b0, 32'h0,        4'd7},  // global
        '{2'd0, 20'h20005, 32'h456,      1'b1, 32'hBBBBB456, 1'b0, 32'h0,        4'd7},  // R7
        '{2'd0, 20'h30005, 32'h789,      1'b1, 32'hCCCCC789, 1'b0, 32'h0,        4'd7},
        '{2'd0, 20'h40005, 32'hABC,      1'b1, 32'hDDDDDABC, 1'b0, 32'h0,        4'd7},
        '{2'd0, 20'h10005, 32'h000,      1'b1, 32'hAAAAA000, 1'b0, 32'h0,        4'd8},  // R8 touch A
        '{2'd1, 20'h50005, 32'hEEEEE001, 1'b0, 32'h0,        1'b0, 32'h0,        4'd8},  // evicts way2
        '{2'd0, 20'h30005, 32'h001,      1'b0, 32'h0,        1'b0, 32'h0,        4'd8},  // R8 C gone
        '{2'd0, 20'h50005, 32'hFFF,      1'b1, 32'hEEEEEFFF, 1'b0, 32'h0,        4'd8},
        '{2'd0, 20'h10005, 32'h010,      1'b1, 32'hAAAAA010, 1'b0, 32'h0,        4'd8},
        '{2'd1, 20'h10005, 32'h12345001, 1'b0, 32'h0,        1'b0, 32'h0,        4'd9},  // R9 refill
        '{2'd0, 20'h10005, 32'h321,      1'b1, 32'h12345321, 1'b0, 32'h0,        4'd9},
        '{2'd0, 20'h20005, 32'h000,      1'b1, 32'hBBBBB000, 1'b0, 32'h0,        4'd9},
        '{2'd0, 20'h40005, 32'h000,      1'b1, 32'hDDDDD000, 1'b0, 32'h0,        4'd9},
        '{2'd0, 20'h50005, 32'h000,      1'b1, 32'hEEEEE000, 1'b0, 32'h0,        4'd9},
        '{2'd0, 20'h10006, 32'h000,      1'b0, 32'h0,        1'b0, 32'h0,        4'd4},  // R4 other set
        '{2'd0, 20'h60005, 32'h000,      1'b0, 32'h0,        1'b0, 32'h0,        4'd4},  // R4 other tag
        '{2'd2, 20'h0A7FF, 32'h77777003, 1'b0, 32'h0,        1'b0, 32'h0,        4'd5},  // R5 dir fill
        '{2'd1, 20'h00029, 32'h99999001, 1'b0, 32'h0,        1'b0, 32'h0,        4'd5},  // same key, leaf
        '{2'd0, 20'h0A400, 32'h000,      1'b0, 32'h0,        1'b1, 32'h77777003, 4'd5},
        '{2'd0, 20'h00029, 32'h0AB,      1'b1, 32'h999990AB, 1'b0, 32'h0,        4'd5},
        '{2'd0, 20'h0A7FF, 32'h000,      1'b0, 32'h0,        1'b1, 32'h77777003, 4'd5},
        '{2'd0, 20'h0AC00, 32'h000,      1'b0, 32'h0,        1'b0, 32'h0,        4'd5},
        '{2'd3, 20'h00000, 32'h0,        1'b0, 32'h0,        1'b0, 32'h0,        4'd6},  // R6 flush
        '{2'd0, 20'h40005, 32'h000,      1'b1, 32'hDDDDD000, 1'b0, 32'h0,        4'd6},  // global kept
        '{2'd0, 20'h10005, 32'h000,      1'b0, 32'h0,        1'b0, 32'h0,        4'd6},
        '{2'd0, 20'h00029, 32'h000,      1'b0, 32'h0,        1'b0, 32'h0,        4'd6},
        '{2'd0, 20'h0A400, 32'h000,      1'b0, 32'h0,        1'b0, 32'h0,        4'd6}
    };

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Compare all response outputs against expected values.
    task automatic check_rsp(input string rq, input logic eh, input logic em, input logic [31:0] epa,
                             input logic ed, input logic [31:0] edent);
        check(rsp_hit == eh,          rq, "rsp_hit",     32'(rsp_hit),  32'(eh));
        check(rsp_miss == em,         rq, "rsp_miss",    32'(rsp_miss), 32'(em));
        check(rsp_pa == epa,          rq, "rsp_pa",      rsp_pa,        epa);
        check(rsp_dir_hit == ed,      rq, "rsp_dir_hit", 32'(rsp_dir_hit), 32'(ed));
        check(rsp_dir_ent == edent,   rq, "rsp_dir_ent", rsp_dir_ent,   edent);
    endtask

    // Drive one strobe for one cycle; results are visible at the following negedge.
    task automatic apply(input logic [1:0] op, input logic [19:0] vpn, input logic [31:0] dat);
        @(negedge clk);
        lk_req    = (op == 2'd0);
        lk_vpn    = vpn;
        lk_off    = dat[11:0];
        fill_req  = (op == 2'd1) || (op == 2'd2);
        fill_pd   = (op == 2'd2);
        fill_vpn  = vpn;
        fill_ent  = dat;
        flush_req = (op == 2'd3);
        @(negedge clk);
        lk_req = 1'b0; fill_req = 1'b0; flush_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_rsp("R1", 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);   // R1 outputs low in reset
        rst_n = 1'b1;
        @(negedge clk);
        check_rsp("R10", 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);  // R10 no strobe, no response

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].vpn, VECS[i].dat);
            if (VECS[i].op == 2'd0)
                check_rsp($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].eh, !VECS[i].eh,
                          VECS[i].epa, VECS[i].ed, VECS[i].edent);
            else
                check_rsp($sformatf("R10 vec%0d", i), 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
        end

        // R11: local fill issued together with a flush survives.
        @(negedge clk);
        fill_req = 1'b1; fill_pd = 1'b0; fill_vpn = 20'h70003; fill_ent = 32'h55555001;
        flush_req = 1'b1;
        @(negedge clk);
        fill_req = 1'b0; flush_req = 1'b0;
        apply(2'd0, 20'h70003, 32'h0EE);
        check_rsp("R11", 1'b1, 1'b0, 32'h555550EE, 1'b0, 32'h0);

        // R10: idle cycle right after a lookup response.
        @(negedge clk);
        check_rsp("R10 idle", 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);

        // R1: a later reset empties the array, including global entries.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(2'd0, 20'h40005, 32'h0);
        check_rsp("R1 global gone", 1'b0, 1'b1, 32'h0, 1'b0, 32'h0);
        apply(2'd0, 20'h70003, 32'h0);
        check_rsp("R1 local gone", 1'b0, 1'b1, 32'h0, 1'b0, 32'h0);

        finish_run();
    end
endmodule